// File: doc/BRIEF.md
# Watchdog and Reset Timeout Timer

This block supervises a processor from a single synchronous clock domain. It drives a system reset and watches a strobe line that running firmware must toggle. When power-good goes low the reset is forced at once. Once power-good is back, the reset stays asserted for a fixed number of timebase ticks and is then released. After release, the firmware gets an extended first window in which to start strobing. After the first strobe edge, a shorter normal window applies. If a window expires without a strobe edge, the block asserts reset again, sets a sticky timeout flag and restarts the reset timeout.

The timebase is chosen by a two-bit mode input. In external mode, each rising edge of a slow external clock is one tick. In the two internal modes, a prescaler divides the system clock down to a one-millisecond tick. Both inputs from outside the clock domain pass through two-flop synchronizers before any edge is detected.

The state machine has three states. HOLD keeps reset asserted while the reset timeout counts. FIRST is the extended window after release. NORMAL is the regular window. The transitions are:
- RELEASE: HOLD to FIRST, when the reset count completes.
- FIRST_KICK: FIRST to NORMAL, on a strobe edge.
- FIRST_EXPIRE: FIRST to HOLD, when the first window runs out.
- KICK: NORMAL to NORMAL, on a strobe edge, which restarts the count.
- EXPIRE: NORMAL to HOLD, when the normal window runs out.
- POWER_LOSS: any state to HOLD, asynchronously, when power-good is low.

Top module: `wdt_supervisor`

## Requirements
- R1: While `pwr_good` is low, `sys_rst` is 1, `wd_timeout` is 0 and all counters are cleared, so each release starts a full reset timeout.
- R2: With `tb_mode` = 2'b00 (external), `sys_rst` stays 1 for 2048 rising edges of `ext_timebase` after `pwr_good` rises.
- R3: In external mode, the normal window is 1024 rising edges of `ext_timebase`, counted from the last strobe edge.
- R4: The first window after every reset release is 4096 external edges in external mode and 1600 ms in both internal modes. Only a strobe edge leaves it.
- R5: In the internal modes (`tb_mode` not 2'b00), one tick lasts CLKS_PER_MS system clocks, and the reset timeout is 200 ms.
- R6: With `tb_mode` = 2'b01, the normal window is 100 ms.
- R7: With `tb_mode` = 2'b10 or 2'b11, the normal window is 1600 ms.
- R8: A rising or falling edge on `wd_strobe` restarts the window and moves FIRST to NORMAL. The edge acts at the third rising clock edge after it is first sampled.
- R9: When a window expires, `sys_rst` rises, `wd_timeout` rises in the same cycle and stays 1 until `pwr_good` goes low, and the reset timeout restarts.
- R10: Strobe edges while `sys_rst` is 1 have no effect on the length of the reset timeout.
- R11: `sys_rst_n` is always the complement of `sys_rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pwr_good | input | 1 | Power good, active low asynchronous clear of the block |
| wd_strobe | input | 1 | Watchdog strobe from the processor; any edge counts |
| ext_timebase | input | 1 | External timebase clock, counted on rising edges |
| tb_mode | input | 2 | 00 external, 01 internal 100 ms, 10/11 internal 1600 ms |
| sys_rst | output | 1 | Reset, active high |
| sys_rst_n | output | 1 | Reset, active low |
| wd_timeout | output | 1 | Sticky flag: a watchdog window expired |

## Verification
Every internal fault in this block shows up at the ports as a change in when `sys_rst` switches. A wrong state or a slipped count moves the release or the expiry by whole ticks. In external mode that is at least four system clocks, and in internal mode at least CLKS_PER_MS system clocks. A behavioural model compares `sys_rst`, `sys_rst_n` and `wd_timeout` on every clock, so a miscompare appears in the cycle where the transition should have happened. A strobe edge that is lost or picked up twice shows up one full window later, as an early or a missing reset.

// File: rtl/wdt_sup_pkg.sv
package wdt_sup_pkg;

    typedef enum logic [1:0] {
        ST_HOLD   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_NORMAL = 2'd2
    } sup_state_e;

    typedef enum logic [1:0] {
        TB_EXTERNAL     = 2'b00,
        TB_INT_SHORT    = 2'b01,
        TB_INT_LONG     = 2'b10,
        TB_INT_LONG_ALT = 2'b11
    } tb_mode_e;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wdt_sync_pair.sv
// Two-flop synchronizer per bit, plus one history flop for edge detection.
module wdt_sync_pair #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] prev
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [2:0] sh;
        always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) begin
                sh <= '0;
            end else begin
                sh <= {sh[1:0], d[i]};
            end
        end
        assign cur[i]  = sh[1];
        assign prev[i] = sh[2];
    end
endmodule

// File: rtl/wdt_tickgen.sv
// Selects the tick source: external edge or millisecond prescaler.
module wdt_tickgen #(
    parameter int CLKS_PER_MS = 50000
) (
    input  logic clk,
    input  logic arst_n,
    input  logic use_ext,
    input  logic ext_rise,
    output logic tick
);
    logic ms_tick;

    if (CLKS_PER_MS <= 1) begin : g_nodiv
        assign ms_tick = 1'b1;
    end else begin : g_div
        localparam int PW = $clog2(CLKS_PER_MS);
        localparam logic [PW-1:0] PLAST = PW'(CLKS_PER_MS - 1);
        logic [PW-1:0] pre_q;
        always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) begin
                pre_q <= '0;
            end else if (pre_q == PLAST) begin
                pre_q <= '0;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
        assign ms_tick = (pre_q == PLAST);
    end

    assign tick = use_ext ? ext_rise : ms_tick;
endmodule

// File: rtl/wdt_sup_fsm.sv
// Supervisor state machine: reset hold, extended first window, normal window.
module wdt_sup_fsm
    import wdt_sup_pkg::*;
#(
    parameter int CNT_W            = 13,
    parameter int EXT_RST_TICKS    = 2048,
    parameter int EXT_WD_TICKS     = 1024,
    parameter int EXT_FIRST_TICKS  = 4096,
    parameter int INT_RST_MS       = 200,
    parameter int INT_WD_SHORT_MS  = 100,
    parameter int INT_WD_LONG_MS   = 1600,
    parameter int INT_FIRST_MS     = 1600
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic             tick,
    input  logic             stb_edge,
    input  tb_mode_e         mode,
    output sup_state_e       state,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] limit,
    output logic             in_reset,
    output logic             timeout_flag
);
    localparam logic [CNT_W-1:0] L_EXT_RST   = CNT_W'(EXT_RST_TICKS);
    localparam logic [CNT_W-1:0] L_EXT_WD    = CNT_W'(EXT_WD_TICKS);
    localparam logic [CNT_W-1:0] L_EXT_FIRST = CNT_W'(EXT_FIRST_TICKS);
    localparam logic [CNT_W-1:0] L_INT_RST   = CNT_W'(INT_RST_MS);
    localparam logic [CNT_W-1:0] L_INT_SHORT = CNT_W'(INT_WD_SHORT_MS);
    localparam logic [CNT_W-1:0] L_INT_LONG  = CNT_W'(INT_WD_LONG_MS);
    localparam logic [CNT_W-1:0] L_INT_FIRST = CNT_W'(INT_FIRST_MS);

    sup_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] lim;
    logic             flag_q, flag_set;
    logic             ext_mode, at_last;

    assign ext_mode = (mode == TB_EXTERNAL);

    // Window length for the current state and mode.
    always_comb begin
        lim = L_INT_LONG;
        unique case (state_q)
            ST_HOLD:  lim = ext_mode ? L_EXT_RST : L_INT_RST;
            ST_FIRST: lim = ext_mode ? L_EXT_FIRST : L_INT_FIRST;
            ST_NORMAL: begin
                unique case (mode)
                    TB_EXTERNAL:     lim = L_EXT_WD;
                    TB_INT_SHORT:    lim = L_INT_SHORT;
                    TB_INT_LONG,
                    TB_INT_LONG_ALT: lim = L_INT_LONG;
                    default:         lim = L_INT_LONG;
                endcase
            end
            default:  lim = L_INT_LONG;
        endcase
    end

    // The comparison uses >= so that a mode change can never skip the end of a window.
    assign at_last = (cnt_q >= (lim - 1'b1));

    // Next-state and count logic.
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        flag_set = 1'b0;
        unique case (state_q)
            ST_HOLD: begin
                if (tick) begin
                    if (at_last) begin          // RELEASE
                        state_d = ST_FIRST;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_FIRST, ST_NORMAL: begin
                if (stb_edge) begin             // FIRST_KICK / KICK
                    state_d = ST_NORMAL;
                    cnt_d   = '0;
                end else if (tick) begin
                    if (at_last) begin          // FIRST_EXPIRE / EXPIRE
                        state_d  = ST_HOLD;
                        cnt_d    = '0;
                        flag_set = 1'b1;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: begin
                state_d = ST_HOLD;
                cnt_d   = '0;
            end
        endcase
    end

    // State register; POWER_LOSS is the asynchronous clear.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            flag_q <= 1'b0;
        end else if (flag_set) begin
            flag_q <= 1'b1;
        end
    end

    // Outputs.
    always_comb begin
        in_reset     = (state_q == ST_HOLD);
        timeout_flag = flag_q;
        state        = state_q;
        cnt          = cnt_q;
        limit        = lim;
    end
endmodule

// File: rtl/wdt_supervisor.sv
module wdt_supervisor
    import wdt_sup_pkg::*;
#(
    parameter int CLKS_PER_MS      = 50000,
    parameter int EXT_RST_TICKS    = 2048,
    parameter int EXT_WD_TICKS     = 1024,
    parameter int EXT_FIRST_TICKS  = 4096,
    parameter int INT_RST_MS       = 200,
    parameter int INT_WD_SHORT_MS  = 100,
    parameter int INT_WD_LONG_MS   = 1600,
    parameter int INT_FIRST_MS     = 1600
) (
    input  logic       clk,
    input  logic       pwr_good,
    input  logic       wd_strobe,
    input  logic       ext_timebase,
    input  logic [1:0] tb_mode,
    output logic       sys_rst,
    output logic       sys_rst_n,
    output logic       wd_timeout
);
    localparam int unsigned MAX_EXT = umax(umax(EXT_RST_TICKS, EXT_WD_TICKS), EXT_FIRST_TICKS);
    localparam int unsigned MAX_INT = umax(umax(INT_RST_MS, INT_FIRST_MS),
                                           umax(INT_WD_SHORT_MS, INT_WD_LONG_MS));
    localparam int CNT_W = $clog2(umax(MAX_EXT, MAX_INT) + 1);

    logic [1:0]       s_cur, s_prev;
    logic             ext_rise, stb_tog, tick, rst_int, flag_int;
    sup_state_e       st;
    logic [CNT_W-1:0] cnt, lim;
    tb_mode_e         mode_e;

    assign mode_e = tb_mode_e'(tb_mode);

    wdt_sync_pair #(.WIDTH(2)) u_sync (
        .clk    (clk),
        .arst_n (pwr_good),
        .d      ({ext_timebase, wd_strobe}),
        .cur    (s_cur),
        .prev   (s_prev)
    );

    assign ext_rise = s_cur[1] & ~s_prev[1];
    assign stb_tog  = s_cur[0] ^ s_prev[0];

    wdt_tickgen #(.CLKS_PER_MS(CLKS_PER_MS)) u_tick (
        .clk      (clk),
        .arst_n   (pwr_good),
        .use_ext  (mode_e == TB_EXTERNAL),
        .ext_rise (ext_rise),
        .tick     (tick)
    );

    wdt_sup_fsm #(
        .CNT_W           (CNT_W),
        .EXT_RST_TICKS   (EXT_RST_TICKS),
        .EXT_WD_TICKS    (EXT_WD_TICKS),
        .EXT_FIRST_TICKS (EXT_FIRST_TICKS),
        .INT_RST_MS      (INT_RST_MS),
        .INT_WD_SHORT_MS (INT_WD_SHORT_MS),
        .INT_WD_LONG_MS  (INT_WD_LONG_MS),
        .INT_FIRST_MS    (INT_FIRST_MS)
    ) u_fsm (
        .clk          (clk),
        .arst_n       (pwr_good),
        .tick         (tick),
        .stb_edge     (stb_tog),
        .mode         (mode_e),
        .state        (st),
        .cnt          (cnt),
        .limit        (lim),
        .in_reset     (rst_int),
        .timeout_flag (flag_int)
    );

    assign sys_rst    = rst_int;
    assign sys_rst_n  = ~rst_int;
    assign wd_timeout = flag_int;
endmodule

// File: rtl/wdt_supervisor_chk.sv
module wdt_supervisor_chk
    import wdt_sup_pkg::*;
#(
    parameter int CNT_W = 13
) (
    input logic             clk,
    input logic             pwr_good,
    input logic             sys_rst,
    input logic             wd_timeout,
    input sup_state_e       state,
    input logic             tick,
    input logic             stb_edge,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] limit
);
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!pwr_good)
        wd_timeout |=> wd_timeout);                                        // R9
    AST_FLAG_WITH_RESET: assert property (@(posedge clk) disable iff (!pwr_good)
        $rose(wd_timeout) |-> sys_rst);                                    // R9
    AST_RELEASE_ON_TICK: assert property (@(posedge clk) disable iff (!pwr_good)
        $fell(sys_rst) |-> $past(tick));                                   // R2
    AST_KICK_ENDS_FIRST: assert property (@(posedge clk) disable iff (!pwr_good)
        (state == ST_FIRST && stb_edge) |=> (state == ST_NORMAL));         // R8
    AST_NO_REENTER_FIRST: assert property (@(posedge clk) disable iff (!pwr_good)
        (state == ST_NORMAL) |=> (state != ST_FIRST));                     // R4
    AST_HOLD_IGNORES_STROBE: assert property (@(posedge clk) disable iff (!pwr_good)
        (state == ST_HOLD && !tick) |=> (cnt == $past(cnt)));              // R10
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!pwr_good)
        (tick && cnt >= limit - 1'b1) |=> (cnt == '0));                    // R3
endmodule

bind wdt_supervisor wdt_supervisor_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .pwr_good   (pwr_good),
    .sys_rst    (sys_rst),
    .wd_timeout (wd_timeout),
    .state      (st),
    .tick       (tick),
    .stb_edge   (stb_tog),
    .cnt        (cnt),
    .limit      (lim)
);

// File: tb/wdt_supervisor_bench.sv
module wdt_supervisor_bench;
    localparam int CPM = 4;

    logic       clk = 1'b0;
    logic       pwr_good = 1'b0;
    logic       wd_strobe = 1'b0;
    logic       ext_timebase = 1'b0;
    logic [1:0] tb_mode = 2'b00;
    logic       sys_rst, sys_rst_n, wd_timeout;

    always #2 clk = ~clk;

    wdt_supervisor #(.CLKS_PER_MS(CPM)) u_wdt_supervisor (
        .clk          (clk),
        .pwr_good     (pwr_good),
        .wd_strobe    (wd_strobe),
        .ext_timebase (ext_timebase),
        .tb_mode      (tb_mode),
        .sys_rst      (sys_rst),
        .sys_rst_n    (sys_rst_n),
        .wd_timeout   (wd_timeout)
    );

    // Behavioural reference model: 0 hold, 1 first window, 2 normal window.
    int    m_state, m_cnt, m_pre;
    bit    m_flag;
    bit    sq[$];
    bit    eq[$];
    int    n_vec = 0, n_bad = 0, cyc = 0, stb_per = 0;
    bit    ext_run = 1'b0, done = 1'b0;
    string cur_req = "R1";

    function automatic void m_clear();
        m_state = 0; m_cnt = 0; m_pre = 0; m_flag = 1'b0;
        sq = '{1'b0, 1'b0, 1'b0};
        eq = '{1'b0, 1'b0, 1'b0};
    endfunction

    function automatic int m_lim();
        bit ext = (tb_mode == 2'b00);
        if (m_state == 0) return ext ? 2048 : 200;
        if (m_state == 1) return ext ? 4096 : 1600;
        if (ext) return 1024;
        return (tb_mode == 2'b01) ? 100 : 1600;
    endfunction

    initial m_clear();

    always @(posedge clk) begin
        if (!pwr_good) begin
            m_clear();
        end else begin
            bit sedge, tk;
            int lim;
            sedge = sq[1] ^ sq[2];
            tk    = (tb_mode == 2'b00) ? (eq[1] & ~eq[2]) : (m_pre == CPM - 1);
            m_pre = (m_pre == CPM - 1) ? 0 : m_pre + 1;
            sq.push_front(wd_strobe);    void'(sq.pop_back());
            eq.push_front(ext_timebase); void'(eq.pop_back());
            lim = m_lim();
            if (m_state != 0 && sedge) begin
                m_state = 2; m_cnt = 0;
            end else if (tk) begin
                if (m_cnt + 1 >= lim) begin
                    if (m_state == 0) m_state = 1;
                    else begin m_state = 0; m_flag = 1'b1; end
                    m_cnt = 0;
                end else begin
                    m_cnt++;
                end
            end
        end
    end

    task automatic check(input bit got, input bit exp, input string req, input string what);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s at cycle %0d: got %0b expected %0b", req, what, cyc, got, exp);
        end
    endtask

    task automatic chk_range(input int got, input int lo, input int hi, input string req, input string what);
        n_vec++;
        if (got < lo || got > hi) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d..%0d", req, what, got, lo, hi);
        end
    endtask

    // One clock: compare at the falling edge, then drive the next inputs.
    task automatic cycle();
        @(negedge clk);
        check(sys_rst, (m_state == 0), cur_req, "sys_rst");
        check(sys_rst_n, (m_state != 0), "R11", "sys_rst_n");
        check(wd_timeout, m_flag, "R9", "wd_timeout");
        cyc++;
        ext_timebase = ext_run ? cyc[1] : 1'b0;
        if (stb_per != 0 && (cyc % stb_per) == 0) wd_strobe = ~wd_strobe;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic wait_rst(input bit level, input int maxc, output int n);
        n = 0;
        while (sys_rst !== level && n < maxc) begin
            cycle();
            n++;
        end
    endtask

    task automatic power_cycle(input logic [1:0] mode);
        pwr_good = 1'b0;
        run(4);
        tb_mode = mode;
        run(2);
        check(sys_rst, 1'b1, "R1", "sys_rst while power low");
        check(wd_timeout, 1'b0, "R1", "flag cleared while power low");
        pwr_good = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        finish_run();
    end

    initial begin
        int n;
        // External timebase: one tick per 4 system clocks.
        ext_run = 1'b1;
        cur_req = "R1";
        power_cycle(2'b00);
        check(sys_rst_n, 1'b0, "R11", "sys_rst_n in reset");
        cur_req = "R2";
        wait_rst(1'b0, 9000, n);
        chk_range(n, 8184, 8200, "R2", "external reset hold cycles");
        cur_req = "R4";
        wait_rst(1'b1, 17000, n);
        chk_range(n, 16376, 16392, "R4", "external first window cycles");
        check(wd_timeout, 1'b1, "R9", "flag set on first window expiry");
        cur_req = "R10";
        stb_per = 50;
        wait_rst(1'b0, 9000, n);
        chk_range(n, 8184, 8200, "R10", "hold length with strobing");
        check(wd_timeout, 1'b1, "R9", "flag still set after release");
        cur_req = "R8";
        stb_per = 3000;
        wait_rst(1'b1, 20000, n);
        chk_range(n, 20000, 20000, "R8", "no reset while strobing");
        stb_per = 0;
        wd_strobe = ~wd_strobe;
        cur_req = "R3";
        wait_rst(1'b1, 5000, n);
        chk_range(n, 4092, 4108, "R3", "external normal window cycles");

        // Internal 100 ms setting.
        ext_run = 1'b0;
        cur_req = "R1";
        power_cycle(2'b01);
        cur_req = "R5";
        wait_rst(1'b0, 1000, n);
        chk_range(n, 794, 808, "R5", "internal reset hold cycles");
        wd_strobe = ~wd_strobe;
        cur_req = "R6";
        wait_rst(1'b1, 1000, n);
        chk_range(n, 396, 410, "R6", "short normal window cycles");
        check(wd_timeout, 1'b1, "R9", "flag after short expiry");
        cur_req = "R9";
        wait_rst(1'b0, 1000, n);
        chk_range(n, 794, 808, "R9", "reset timeout restarted after expiry");
        cur_req = "R4";
        wait_rst(1'b1, 7000, n);
        chk_range(n, 6394, 6408, "R4", "internal first window cycles");

        // Internal 1600 ms setting, both encodings.
        cur_req = "R1";
        power_cycle(2'b10);
        cur_req = "R5";
        wait_rst(1'b0, 1000, n);
        chk_range(n, 794, 808, "R5", "long-mode reset hold cycles");
        wd_strobe = ~wd_strobe;
        cur_req = "R7";
        wait_rst(1'b1, 7000, n);
        chk_range(n, 6396, 6410, "R7", "long normal window, mode 10");

        cur_req = "R1";
        power_cycle(2'b11);
        wait_rst(1'b0, 1000, n);
        wd_strobe = ~wd_strobe;
        run(1000);
        check(sys_rst, 1'b0, "R1", "running before power loss");
        pwr_good = 1'b0;
        run(3);
        check(sys_rst, 1'b1, "R1", "reset on power loss");
        check(wd_timeout, 1'b0, "R1", "flag clear on power loss");
        pwr_good = 1'b1;
        wait_rst(1'b0, 1000, n);
        chk_range(n, 794, 808, "R1", "full hold after power loss");
        wd_strobe = ~wd_strobe;
        cur_req = "R7";
        wait_rst(1'b1, 7000, n);
        chk_range(n, 6396, 6410, "R7", "long normal window, mode 11");
        run(5);
        finish_run();
    end
endmodule